// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

This block is a sequential restoring divider that returns a 16-bit quotient and a 16-bit remainder. One fixed-length engine covers five arithmetic modes: unsigned and signed integer division with either a 32-bit or a 16-bit dividend, and a signed Q15 fractional division. Every divide is launched by a one-cycle start strobe. It is accepted only when the engine is idle and then runs for a fixed number of active steps, whatever the mode or the operand values.

The steps are used as follows. One step takes the magnitudes of the operands and finds overflow and zero-divisor cases early. Sixteen steps each shift and subtract. One last step applies the signs and writes the results. A hold input lets a surrounding pipeline freeze the divide between any two steps and resume it later with all partial state intact. When the result registers are loaded, a one-cycle done pulse is raised. The results and the divide-by-zero and overflow flags then stay valid until the next divide completes.

Top module: `iter_div`

## Requirements
- R1: The mode input selects the operation by code: 0 signed fractional Q15 16/16, 1 signed 32/16, 2 unsigned 32/16, 3 signed 16/16, 4 unsigned 16/16. The same operands give results as defined for the selected mode.
- R2: In the 32/16 modes the dividend is the concatenation {dvd_hi, dvd_lo}, with dvd_hi as the upper half.
- R3: In the 16/16 modes only dvd_lo is used. It is zero-extended in unsigned mode and sign-extended in signed mode, and dvd_hi has no effect on any output.
- R4: A start accepted in an idle cycle is followed by exactly 18 active busy cycles, 19 cycles in all. done is high for exactly one cycle, the cycle after the last busy cycle, and busy is low while done is high.
- R5: While busy and hold are both high, the divide makes no progress. Cycles with hold high are not counted among the 18 active cycles, and the final results equal those of an uninterrupted divide.
- R6: Signed integer quotients truncate toward zero, and a nonzero remainder takes the sign of the dividend. Unsigned results satisfy dividend = quotient*divisor + remainder with remainder < divisor.
- R7: In fractional mode the quotient is trunc(a*32768/b) and the remainder is (a*32768) rem b, with a = signed dvd_lo and b = signed divisor. Overflow is flagged whenever |a| >= |b|.
- R8: A zero divisor sets div_zero, clears ovf, and drives quotient and remainder to 16'hFFFF.
- R9: A nonzero divisor whose true quotient does not fit the mode's 16-bit range (0..65535 unsigned, -32768..32767 signed) sets ovf and drives quotient and remainder to 16'hFFFF.
- R10: A start strobe while busy is ignored. The running divide finishes with the operands and mode captured at its own start.
- R11: After reset, busy, done, div_zero, ovf, quotient and remainder are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, accepted when idle |
| hold | input | 1 | Freezes the running divide |
| mode | input | 3 | Operation select (see R1) |
| dvd_hi | input | 16 | Upper dividend word (32/16 modes) |
| dvd_lo | input | 16 | Lower dividend word, or the whole 16-bit dividend |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient not representable |

## Verification
Two things can meet in one cycle: a pipeline freeze and a new launch request, each arriving while a divide is in flight, including its final step. The bench drives hold from a pseudo-random bit on every cycle of some divides and, in other divides, raises start with altered operands and mode on every busy cycle. It then requires the hold-free busy cycles to number exactly 18 and the results to match the arithmetic of the original operands.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        MD_FRAC = 3'd0,
        MD_S32  = 3'd1,
        MD_U32  = 3'd2,
        MD_S16  = 3'd3,
        MD_U16  = 3'd4
    } div_mode_e;

endpackage

// File: rtl/div_prep.sv
// Normalise step: widen dividend per mode, take magnitudes, early flags.
module div_prep
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   mode,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dsr,
    output logic [W-1:0] rem0,
    output logic [W-1:0] acc0,
    output logic [W-1:0] dmag,
    output logic         neg_q,
    output logic         neg_r,
    output logic         sgn,
    output logic         dz,
    output logic         pre_ovf
);
    localparam int DW = 2 * W;

    logic           is_frac;
    logic           is_wide;
    logic [DW-1:0]  ext_lo;
    logic [DW-1:0]  dvd;
    logic [DW-1:0]  mag;
    logic [W-1:0]   amag;
    logic           sn;
    logic           sd;

    always_comb begin
        is_frac = (mode == MD_FRAC);
        is_wide = (mode == MD_S32) || (mode == MD_U32);
        sgn     = is_frac || (mode == MD_S32) || (mode == MD_S16);
        ext_lo  = {{W{sgn & lo[W-1]}}, lo};
        if (is_wide)      dvd = {hi, lo};
        else if (is_frac) dvd = ext_lo << (W - 1);
        else              dvd = ext_lo;
        sn      = sgn & dvd[DW-1];
        sd      = sgn & dsr[W-1];
        mag     = sn ? (~dvd + 1'b1) : dvd;
        dmag    = sd ? (~dsr + 1'b1) : dsr;
        amag    = (sgn & lo[W-1]) ? (~lo + 1'b1) : lo;
        dz      = (dsr == '0);
        neg_q   = sn ^ sd;
        neg_r   = sn;
        if (is_frac) pre_ovf = !dz && (amag >= dmag);
        else         pre_ovf = !dz && (mag[DW-1:W] >= dmag);
        rem0    = mag[DW-1:W];
        acc0    = mag[W-1:0];
    end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration.
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] acc_n
);
    logic [W:0] sh;
    logic [W:0] diff;
    logic       ge;

    always_comb begin
        sh    = {rem, acc[W-1]};
        diff  = sh - {1'b0, dmag};
        ge    = (sh >= {1'b0, dmag});
        rem_n = ge ? diff[W-1:0] : sh[W-1:0];
        acc_n = {acc[W-2:0], ge};
    end
endmodule

// File: rtl/div_fix.sv
// Final step: range check and sign correction.
module div_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] qmag,
    input  logic [W-1:0] rmag,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         sgn,
    input  logic         dz,
    input  logic         pre_ovf,
    output logic [W-1:0] quot,
    output logic [W-1:0] rmd,
    output logic         ovf
);
    localparam logic [W-1:0] MINMAG = {1'b1, {(W-1){1'b0}}};

    logic rng;
    logic bad;

    always_comb begin
        rng  = sgn && (neg_q ? (qmag > MINMAG) : (qmag >= MINMAG));
        ovf  = !dz && (pre_ovf || rng);
        bad  = dz || ovf;
        quot = bad ? '1 : (neg_q ? (~qmag + 1'b1) : qmag);
        rmd  = bad ? '1 : (neg_r ? (~rmag + 1'b1) : rmag);
    end
endmodule

// File: rtl/iter_div.sv
module iter_div
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         hold,
    input  logic [2:0]   mode,
    input  logic [15:0]  dvd_hi,
    input  logic [15:0]  dvd_lo,
    input  logic [15:0]  divisor,
    output logic [15:0]  quotient,
    output logic [15:0]  remainder,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic         ovf
);
    localparam int STEPS = W + 2;
    localparam int LAST  = STEPS - 1;
    localparam int CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [2:0]    mode;
        logic [W-1:0]  raw_hi;
        logic [W-1:0]  raw_lo;
        logic [W-1:0]  raw_dsr;
        logic [W-1:0]  dmag;
        logic [W-1:0]  rem;
        logic [W-1:0]  acc;
        logic          neg_q;
        logic          neg_r;
        logic          sgn;
        logic          dz;
        logic          povf;
        logic          done;
        logic [W-1:0]  quot;
        logic [W-1:0]  rmd;
        logic          dz_o;
        logic          ovf_o;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] p_rem0, p_acc0, p_dmag;
    logic         p_negq, p_negr, p_sgn, p_dz, p_povf;
    logic [W-1:0] s_rem, s_acc;
    logic [W-1:0] f_quot, f_rmd;
    logic         f_ovf;

    div_prep #(.W(W)) u_prep (
        .mode    (st_q.mode),
        .hi      (st_q.raw_hi),
        .lo      (st_q.raw_lo),
        .dsr     (st_q.raw_dsr),
        .rem0    (p_rem0),
        .acc0    (p_acc0),
        .dmag    (p_dmag),
        .neg_q   (p_negq),
        .neg_r   (p_negr),
        .sgn     (p_sgn),
        .dz      (p_dz),
        .pre_ovf (p_povf)
    );

    div_step #(.W(W)) u_step (
        .rem   (st_q.rem),
        .acc   (st_q.acc),
        .dmag  (st_q.dmag),
        .rem_n (s_rem),
        .acc_n (s_acc)
    );

    div_fix #(.W(W)) u_fix (
        .qmag    (st_q.acc),
        .rmag    (st_q.rem),
        .neg_q   (st_q.neg_q),
        .neg_r   (st_q.neg_r),
        .sgn     (st_q.sgn),
        .dz      (st_q.dz),
        .pre_ovf (st_q.povf),
        .quot    (f_quot),
        .rmd     (f_rmd),
        .ovf     (f_ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.cnt     = '0;
                st_d.mode    = mode;
                st_d.raw_hi  = dvd_hi;
                st_d.raw_lo  = dvd_lo;
                st_d.raw_dsr = divisor;
            end
        end else if (!hold) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == '0) begin
                st_d.rem   = p_rem0;
                st_d.acc   = p_acc0;
                st_d.dmag  = p_dmag;
                st_d.neg_q = p_negq;
                st_d.neg_r = p_negr;
                st_d.sgn   = p_sgn;
                st_d.dz    = p_dz;
                st_d.povf  = p_povf;
            end else if (st_q.cnt == CW'(LAST)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.cnt   = '0;
                st_d.quot  = f_quot;
                st_d.rmd   = f_rmd;
                st_d.dz_o  = st_q.dz;
                st_d.ovf_o = f_ovf;
            end else begin
                st_d.rem = s_rem;
                st_d.acc = s_acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quotient  = st_q.quot;
    assign remainder = st_q.rmd;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign div_zero  = st_q.dz_o;
    assign ovf       = st_q.ovf_o;

    p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt <= CW'(LAST)));
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hold) |=> (busy && $stable(st_q.cnt) && $stable(st_q.rem) && $stable(st_q.acc)));
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.raw_hi) && $stable(st_q.raw_lo)
                             && $stable(st_q.raw_dsr) && $stable(st_q.mode)));
    p_zero_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (!ovf && quotient == '1 && remainder == '1));
    p_ovf_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (quotient == '1 && remainder == '1));
    p_rem_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf && !div_zero && st_q.neg_r && remainder != '0) |-> remainder[15]);
endmodule

// File: tb/tb_iter_div.sv
module tb_iter_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hold = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic [15:0] quotient, remainder;
    logic        busy, done, div_zero, ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2457;

    always #4 clk = ~clk;

    iter_div dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold(hold), .mode(mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .busy(busy), .done(done),
        .div_zero(div_zero), .ovf(ovf)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Arithmetic reference model for every mode.
    task automatic model(input logic [2:0] m, input logic [15:0] h, input logic [15:0] l,
                         input logic [15:0] d, output logic [15:0] eq, output logic [15:0] er,
                         output bit edz, output bit eov);
        longint n, dv, q, r, a;
        bit sg;
        edz = 1'b0; eov = 1'b0; q = 0; r = 0;
        sg = (m == 3'd0) || (m == 3'd1) || (m == 3'd3);
        dv = sg ? longint'($signed(d)) : longint'(d);
        case (m)
            3'd0: n = longint'($signed(l)) * 32768;
            3'd1: n = longint'($signed({h, l}));
            3'd2: n = longint'({h, l});
            3'd3: n = longint'($signed(l));
            default: n = longint'(l);
        endcase
        if (d == 16'h0) edz = 1'b1;
        else begin
            q = n / dv;
            r = n % dv;
            if (m == 3'd0) begin
                a = longint'($signed(l));
                if ((a < 0 ? -a : a) >= (dv < 0 ? -dv : dv)) eov = 1'b1;
            end else if (sg) eov = (q > 32767) || (q < -32768);
            else eov = (q > 65535);
        end
        if (edz || eov) begin eq = 16'hFFFF; er = 16'hFFFF; end
        else begin eq = q[15:0]; er = r[15:0]; end
    endtask

    // use_hold: random freeze; poke: start with altered operands while busy.
    task automatic do_div(input logic [2:0] m, input logic [15:0] h, input logic [15:0] l,
                          input logic [15:0] d, input bit use_hold, input bit poke,
                          input string tag_ovr);
        logic [15:0] eq, er;
        bit edz, eov;
        int active, n;
        string tag;
        model(m, h, l, d, eq, er, edz, eov);
        @(negedge clk);
        mode = m; dvd_hi = h; dvd_lo = l; divisor = d; start = 1'b1; hold = 1'b0;
        @(negedge clk);
        start = 1'b0;
        active = 0; n = 0;
        while (!done && n < 300) begin
            lfsr = nxt(lfsr);
            hold = use_hold ? lfsr[3] : 1'b0;
            if (poke && busy) begin
                start = 1'b1; mode = lfsr[2:0]; dvd_hi = lfsr[31:16];
                dvd_lo = lfsr[15:0]; divisor = lfsr[23:8];
            end
            if (busy && !hold) active++;
            @(negedge clk);
            n++;
        end
        hold = 1'b0; start = 1'b0;
        chk(active == 18, use_hold ? "R5 active cycles" : "R4 active cycles", active, 18);
        if (tag_ovr != "") tag = tag_ovr;
        else if (edz) tag = "R8";
        else if (eov) tag = "R9";
        else if (m == 3'd0) tag = "R7";
        else if ((m == 3'd1 && (h[15] || d[15])) || (m == 3'd3 && (l[15] || d[15]))) tag = "R6";
        else if (m == 3'd1 || m == 3'd2) tag = "R2";
        else tag = "R3";
        chk(done && quotient == eq && remainder == er && div_zero == edz && ovf == eov,
            tag, {16'h0, div_zero, ovf, quotient, remainder}, {16'h0, edz, eov, eq, er});
        @(negedge clk);
        chk(!done, "R4 done width", done, 0);
    endtask

    function automatic logic [31:0] cdvd(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0007;  3: return 32'h0000_7FFF;
            4: return 32'h0000_8000;  5: return 32'h0000_FFFF;
            6: return 32'h0001_7FFF;  7: return 32'h7FFF_FFFF;
            8: return 32'h8000_0000;  9: return 32'hFFFF_FFFF;
            10: return 32'hFFFF_8000; default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [15:0] cdsr(input int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0002;
            3: return 16'h0003; 4: return 16'h7FFF; 5: return 16'h8000;
            6: return 16'hFFFF; 7: return 16'hFFFE; 8: return 16'h1234;
            default: return 16'h00FF;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        chk(!busy && !done && !div_zero && !ovf && quotient == 0 && remainder == 0,
            "R11 reset state", {busy, done, div_zero, ovf, quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: one operand pair, each mode code gives its own result
        do_div(3'd3, 16'h0, 16'hFFFF, 16'h0002, 0, 0, "R1 signed16");
        do_div(3'd4, 16'h0, 16'hFFFF, 16'h0002, 0, 0, "R1 unsigned16");
        do_div(3'd0, 16'h0, 16'h2000, 16'h4000, 0, 0, "R1 frac");

        // Corner sweep over all modes
        for (int m = 0; m < 5; m++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 10; j++) begin
                    logic [31:0] v;
                    v = cdvd(i);
                    do_div(3'(m), v[31:16], v[15:0], cdsr(j), 0, 0, "");
                end

        // R3: upper word must not matter in the 16/16 modes
        for (int k = 0; k < 40; k++) begin
            lfsr = nxt(lfsr);
            do_div(k[0] ? 3'd3 : 3'd4, lfsr[31:16], lfsr[15:0], lfsr[23:8] | 16'h1, 0, 0, "R3 hi ignored");
        end

        // Pseudo-random sweep; upper word narrowed to keep many 32/16 results in range
        for (int k = 0; k < 1500; k++) begin
            logic [15:0] h, l, d;
            lfsr = nxt(lfsr); h = lfsr[15:0];
            lfsr = nxt(lfsr); l = lfsr[15:0];
            lfsr = nxt(lfsr); d = lfsr[15:0];
            if (k[1]) h = {{8{h[15]}}, h[7:0]};
            do_div(3'(k % 5), h, l, d, 0, 0, "");
        end

        // R5: random hold freezes
        for (int k = 0; k < 200; k++) begin
            lfsr = nxt(lfsr);
            do_div(3'(k % 5), {{12{lfsr[31]}}, lfsr[19:16]}, lfsr[15:0], lfsr[27:12], 1, 0, "");
        end

        // R10: start strobes during busy are ignored
        for (int k = 0; k < 100; k++) begin
            lfsr = nxt(lfsr);
            do_div(3'(k % 5), {12'h0, lfsr[19:16]}, lfsr[15:0], lfsr[30:15], k[0], 1, "R10 restart ignored");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule